// File: doc/BRIEF.md
# Domain-Tagged Permission Lookaside Buffer

This block is a small, fully associative store of memory-permission entries. Every load, store or instruction fetch presents a word address, an access kind and the current protection-domain number. The block answers one cycle later with exactly one of three outcomes: allowed, fault, or miss. It translates nothing. It returns only a 2-bit permission and the verdict that follows from it.

Each entry carries a domain number, a 26-bit region tag with a per-bit ignore mask, and a payload. The payload is either one permission for the whole region or a packed vector with one 2-bit permission per word of a 64-word block. Ignore bits let a single entry stand for any power-of-two group of 64-word blocks, for example a 256 KB span. When no entry matches, the block raises a refill request that carries the address and domain. The table walker later writes an entry through the fill port, and the requester retries. A flush input drops every entry at once, which is how permissions are revoked.

Top module: `perm_lookaside`

## Requirements
- R1: After reset every output is low and no entry is valid, so the first lookup reports a miss.
- R2: An entry can match only when its domain number equals `cur_domain`. A request from any other domain does not see it.
- R3: The request tag is `req_addr[31:6]`. It matches an entry when it agrees with the entry tag on every bit whose `fill_mask` bit is 0. Bits with mask 1 are ignored.
- R4: A region entry (`fill_is_vec`=0) gives `fill_perm` to every word it covers.
- R5: A vector entry (`fill_is_vec`=1) gives word i, where i = `req_addr[5:0]`, the permission held in vector bits [2i+1:2i].
- R6: Permission codes are 00 none, 01 read-only, 10 read-write and 11 execute-read. Access kinds are 00 load, 01 store, 10 fetch and 11 reserved. A load is allowed for any code except 00. A store is allowed only for 10. A fetch is allowed only for 11. A reserved kind always faults on a hit.
- R7: When several entries match, the one with the fewest ignore bits decides. On a tie, the lowest slot index decides.
- R8: The result appears in the cycle after the request. It shows `rsp_valid` together with exactly one of `rsp_ok`, `rsp_fault` or `rsp_miss`, and `rsp_perm` holds the permission used (00 on a miss). Without a request, all result outputs are low.
- R9: A miss raises `refill_req` in the same cycle as `rsp_miss`, with `refill_addr` and `refill_domain` equal to the request's address and domain.
- R10: Fills write slots in round-robin order, starting at slot 0 and wrapping after slot 7. The ninth fill therefore replaces the first.
- R11: `flush` invalidates every entry, and takes effect for requests in the following cycle. A fill in the same cycle as a flush is dropped.
- R12: A lookup in the same cycle as a fill sees the entries as they were before that fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Access check request |
| req_addr | input | 32 | Word address of the access |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| cur_domain | input | 8 | Current protection domain |
| fill_valid | input | 1 | Write a new entry |
| fill_domain | input | 8 | Domain of the new entry |
| fill_tag | input | 26 | Region tag of the new entry |
| fill_mask | input | 26 | Ignore mask, 1 = bit not compared |
| fill_is_vec | input | 1 | 1 = per-word vector payload, 0 = single permission |
| fill_perm | input | 2 | Region permission |
| fill_vec | input | 128 | Per-word permissions, 2 bits per word |
| rsp_valid | output | 1 | Result present |
| rsp_ok | output | 1 | Hit, access allowed |
| rsp_fault | output | 1 | Hit, access denied |
| rsp_miss | output | 1 | No matching entry |
| rsp_perm | output | 2 | Permission of the deciding entry |
| refill_req | output | 1 | Refill needed |
| refill_addr | output | 32 | Address to refill |
| refill_domain | output | 8 | Domain to refill |

## Verification
Every verdict, the refill request and its address are due exactly one clock edge after the request is presented. Fills and flushes change what a request sees starting from the next cycle. The bench drives each cycle's inputs just after an edge, lets its behavioural model compute the verdict from the entries as they stood before that edge, and samples the outputs 1 ns after the following edge. This matches the one-register latency, and it also catches a design that lets a same-cycle fill leak into the lookup.

// File: rtl/plb_pkg.sv
package plb_pkg;
    localparam int PKG_ADDR_W = 32;
    localparam int PKG_WIDX_W = 6;

    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_RO   = 2'b01,
        PERM_RW   = 2'b10,
        PERM_XR   = 2'b11
    } perm_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_e;

    function automatic logic perm_allows(input logic [1:0] p, input logic [1:0] a);
        logic ok;
        case (a)
            ACC_LOAD:  ok = (p != PERM_NONE);
            ACC_STORE: ok = (p == PERM_RW);
            ACC_FETCH: ok = (p == PERM_XR);
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/plb_tag_match.sv
module plb_tag_match #(
    parameter int DOM_W = 8,
    parameter int TAG_W = 26
) (
    input  logic             e_valid,
    input  logic [DOM_W-1:0] e_dom,
    input  logic [TAG_W-1:0] e_tag,
    input  logic [TAG_W-1:0] e_mask,
    input  logic [DOM_W-1:0] q_dom,
    input  logic [TAG_W-1:0] q_tag,
    output logic             hit
);
    logic [TAG_W-1:0] diff;

    always_comb begin
        diff = (e_tag ^ q_tag) & ~e_mask;
        hit  = e_valid && (e_dom == q_dom) && (diff == '0);
    end
endmodule

// File: rtl/plb_prio_pick.sv
module plb_prio_pick #(
    parameter int N     = 8,
    parameter int TAG_W = 26
) (
    input  logic [N-1:0]            hit,
    input  logic [N-1:0][TAG_W-1:0] mask,
    output logic                    any,
    output logic [$clog2(N)-1:0]    idx,
    output logic [N-1:0]            sel
);
    localparam int CNT_W = $clog2(TAG_W + 1);

    logic [N-1:0][CNT_W-1:0] wild;
    logic [CNT_W-1:0]        best;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            wild[i] = CNT_W'($countones(mask[i]));
        end
        any  = 1'b0;
        idx  = '0;
        best = '1;
        sel  = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i] && (!any || wild[i] < best)) begin
                any  = 1'b1;
                best = wild[i];
                idx  = ($clog2(N))'(i);
            end
        end
        if (any) begin
            sel[idx] = 1'b1;
        end
    end
endmodule

// File: rtl/perm_lookaside.sv
module perm_lookaside
    import plb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int DOM_W   = 8,
    parameter int ADDR_W  = PKG_ADDR_W,
    parameter int WIDX_W  = PKG_WIDX_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [1:0]                 req_kind,
    input  logic [DOM_W-1:0]           cur_domain,
    input  logic                       fill_valid,
    input  logic [DOM_W-1:0]           fill_domain,
    input  logic [ADDR_W-WIDX_W-1:0]   fill_tag,
    input  logic [ADDR_W-WIDX_W-1:0]   fill_mask,
    input  logic                       fill_is_vec,
    input  logic [1:0]                 fill_perm,
    input  logic [2*(1<<WIDX_W)-1:0]   fill_vec,
    output logic                       rsp_valid,
    output logic                       rsp_ok,
    output logic                       rsp_fault,
    output logic                       rsp_miss,
    output logic [1:0]                 rsp_perm,
    output logic                       refill_req,
    output logic [ADDR_W-1:0]          refill_addr,
    output logic [DOM_W-1:0]           refill_domain
);
    localparam int TAG_W = ADDR_W - WIDX_W;
    localparam int VEC_W = 2 * (1 << WIDX_W);
    localparam int PTR_W = $clog2(ENTRIES);

    typedef struct packed {
        logic             valid;
        logic [DOM_W-1:0] dom;
        logic [TAG_W-1:0] tag;
        logic [TAG_W-1:0] mask;
        logic             is_vec;
        logic [1:0]       perm;
        logic [VEC_W-1:0] vec;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic [PTR_W-1:0]     rr;
        logic                 rsp_valid;
        logic                 rsp_ok;
        logic                 rsp_fault;
        logic                 rsp_miss;
        logic [1:0]           rsp_perm;
        logic                 refill_req;
        logic [ADDR_W-1:0]    refill_addr;
        logic [DOM_W-1:0]     refill_dom;
    } state_t;

    state_t st_d, st_q;

    logic [TAG_W-1:0]              q_tag;
    logic [WIDX_W-1:0]             q_widx;
    logic [ENTRIES-1:0]            hit_vec;
    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0][TAG_W-1:0] mask_vec;
    logic                          any_hit;
    logic [PTR_W-1:0]              pick_idx;
    logic [ENTRIES-1:0]            pick_sel;
    entry_t                        pick_ent;
    logic [1:0]                    hit_perm;
    logic                          hit_allow;

    assign q_tag  = req_addr[ADDR_W-1:WIDX_W];
    assign q_widx = req_addr[WIDX_W-1:0];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign mask_vec[g]  = st_q.ent[g].mask;
        assign valid_vec[g] = st_q.ent[g].valid;
        plb_tag_match #(.DOM_W(DOM_W), .TAG_W(TAG_W)) i_match (
            .e_valid (st_q.ent[g].valid),
            .e_dom   (st_q.ent[g].dom),
            .e_tag   (st_q.ent[g].tag),
            .e_mask  (st_q.ent[g].mask),
            .q_dom   (cur_domain),
            .q_tag   (q_tag),
            .hit     (hit_vec[g])
        );
    end

    plb_prio_pick #(.N(ENTRIES), .TAG_W(TAG_W)) i_pick (
        .hit  (hit_vec),
        .mask (mask_vec),
        .any  (any_hit),
        .idx  (pick_idx),
        .sel  (pick_sel)
    );

    always_comb begin
        st_d      = st_q;
        pick_ent  = st_q.ent[pick_idx];
        hit_perm  = pick_ent.is_vec ? pick_ent.vec[{q_widx, 1'b0} +: 2] : pick_ent.perm;
        hit_allow = perm_allows(hit_perm, req_kind);

        // verdict, due one cycle after the request
        st_d.rsp_valid  = req_valid;
        st_d.rsp_ok     = req_valid && any_hit && hit_allow;
        st_d.rsp_fault  = req_valid && any_hit && !hit_allow;
        st_d.rsp_miss   = req_valid && !any_hit;
        st_d.rsp_perm   = (req_valid && any_hit) ? hit_perm : 2'b00;
        st_d.refill_req = req_valid && !any_hit;
        if (req_valid && !any_hit) begin
            st_d.refill_addr = req_addr;
            st_d.refill_dom  = cur_domain;
        end

        // entry storage: flush wins over a same-cycle fill
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.ent[i].valid = 1'b0;
            end
        end else if (fill_valid) begin
            st_d.ent[st_q.rr].valid  = 1'b1;
            st_d.ent[st_q.rr].dom    = fill_domain;
            st_d.ent[st_q.rr].tag    = fill_tag;
            st_d.ent[st_q.rr].mask   = fill_mask;
            st_d.ent[st_q.rr].is_vec = fill_is_vec;
            st_d.ent[st_q.rr].perm   = fill_perm;
            st_d.ent[st_q.rr].vec    = fill_vec;
            st_d.rr = (st_q.rr == PTR_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid     = st_q.rsp_valid;
    assign rsp_ok        = st_q.rsp_ok;
    assign rsp_fault     = st_q.rsp_fault;
    assign rsp_miss      = st_q.rsp_miss;
    assign rsp_perm      = st_q.rsp_perm;
    assign refill_req    = st_q.refill_req;
    assign refill_addr   = st_q.refill_addr;
    assign refill_domain = st_q.refill_dom;

    // ---------------- assertions ----------------
    p_one_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_ok, rsp_fault, rsp_miss}) == 1));

    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_ok || rsp_fault || rsp_miss || refill_req));

    p_answer_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_refill_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |-> rsp_miss);

    p_pick_in_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pick_sel) && ((pick_sel & ~hit_vec) == '0));

    p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0));

    p_rr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=>
            (st_q.rr == (($past(st_q.rr) == PTR_W'(ENTRIES - 1)) ? '0 : $past(st_q.rr) + 1'b1)));
endmodule

// File: tb/test_perm_lookaside.sv
module test_perm_lookaside;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         flush;
    logic         req_valid;
    logic [31:0]  req_addr;
    logic [1:0]   req_kind;
    logic [7:0]   cur_domain;
    logic         fill_valid;
    logic [7:0]   fill_domain;
    logic [25:0]  fill_tag;
    logic [25:0]  fill_mask;
    logic         fill_is_vec;
    logic [1:0]   fill_perm;
    logic [127:0] fill_vec;
    logic         rsp_valid, rsp_ok, rsp_fault, rsp_miss, refill_req;
    logic [1:0]   rsp_perm;
    logic [31:0]  refill_addr;
    logic [7:0]   refill_domain;

    int n_checks = 0;
    int n_fails  = 0;

    // behavioural reference state
    bit           m_valid [8];
    logic [7:0]   m_dom   [8];
    logic [25:0]  m_tag   [8];
    logic [25:0]  m_mask  [8];
    bit           m_isvec [8];
    logic [1:0]   m_perm  [8];
    logic [127:0] m_vec   [8];
    int           m_rr;

    always #5 clk = ~clk;

    perm_lookaside i_perm_lookaside (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind), .cur_domain(cur_domain),
        .fill_valid(fill_valid), .fill_domain(fill_domain), .fill_tag(fill_tag), .fill_mask(fill_mask),
        .fill_is_vec(fill_is_vec), .fill_perm(fill_perm), .fill_vec(fill_vec),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_miss(rsp_miss),
        .rsp_perm(rsp_perm), .refill_req(refill_req), .refill_addr(refill_addr),
        .refill_domain(refill_domain)
    );

    function automatic bit allows(input logic [1:0] p, input logic [1:0] k);
        if (k == 2'b00) return p != 2'b00;
        if (k == 2'b01) return p == 2'b10;
        if (k == 2'b10) return p == 2'b11;
        return 1'b0;
    endfunction

    task automatic idle_inputs();
        flush = 0; req_valid = 0; req_addr = '0; req_kind = '0; cur_domain = '0;
        fill_valid = 0; fill_domain = '0; fill_tag = '0; fill_mask = '0;
        fill_is_vec = 0; fill_perm = '0; fill_vec = '0;
    endtask

    // one clock: predict, update model, clock, compare
    task automatic cyc(input string rq);
        int best = -1;
        int bestc = 99;
        logic [1:0] p = 2'b00;
        bit ev, eok, efl, ems;
        logic [8:0] exp_v, act_v;
        for (int i = 0; i < 8; i++) begin
            if (m_valid[i] && m_dom[i] == cur_domain &&
                (((m_tag[i] ^ req_addr[31:6]) & ~m_mask[i]) == '0) &&
                $countones(m_mask[i]) < bestc) begin
                best  = i;
                bestc = $countones(m_mask[i]);
            end
        end
        if (best >= 0) p = m_isvec[best] ? m_vec[best][2*req_addr[5:0] +: 2] : m_perm[best];
        ev  = req_valid;
        eok = req_valid && best >= 0 && allows(p, req_kind);
        efl = req_valid && best >= 0 && !allows(p, req_kind);
        ems = req_valid && best < 0;
        if (!(req_valid && best >= 0)) p = 2'b00;
        exp_v = {ev, eok, efl, ems, p, ems, 2'b00};
        if (flush) begin
            for (int i = 0; i < 8; i++) m_valid[i] = 0;
        end else if (fill_valid) begin
            m_valid[m_rr] = 1; m_dom[m_rr] = fill_domain; m_tag[m_rr] = fill_tag;
            m_mask[m_rr] = fill_mask; m_isvec[m_rr] = fill_is_vec;
            m_perm[m_rr] = fill_perm; m_vec[m_rr] = fill_vec;
            m_rr = (m_rr + 1) % 8;
        end
        @(posedge clk);
        #1;
        act_v = {rsp_valid, rsp_ok, rsp_fault, rsp_miss, rsp_perm, refill_req, 2'b00};
        n_checks++;
        if (act_v !== exp_v) begin
            n_fails++;
            $display("FAIL %s: {valid,ok,fault,miss,perm,refill} got %b expected %b", rq, act_v[8:2], exp_v[8:2]);
        end else if (ems && (refill_addr !== req_addr || refill_domain !== cur_domain)) begin
            n_fails++;
            $display("FAIL %s: refill got %h/%h expected %h/%h", rq, refill_addr, refill_domain, req_addr, cur_domain);
        end
        idle_inputs();
    endtask

    task automatic lookup(input logic [25:0] tag, input logic [5:0] w, input logic [1:0] k,
                          input logic [7:0] d, input string rq);
        req_valid = 1; req_addr = {tag, w}; req_kind = k; cur_domain = d;
        cyc(rq);
    endtask

    task automatic set_fill(input logic [7:0] d, input logic [25:0] tag, input logic [25:0] mask,
                            input bit isv, input logic [1:0] p, input logic [127:0] v);
        fill_valid = 1; fill_domain = d; fill_tag = tag; fill_mask = mask;
        fill_is_vec = isv; fill_perm = p; fill_vec = v;
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [127:0] vpat;
        for (int i = 0; i < 8; i++) m_valid[i] = 0;
        m_rr = 0;
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        cyc("R1");                                        // reset state, idle
        lookup(26'h0000007, 6'd0, 2'b00, 8'd1, "R1");     // empty -> miss + refill (R9)

        // R12: fill and lookup together see old contents
        set_fill(8'd1, 26'h0000007, '0, 0, 2'b01, '0);
        lookup(26'h0000007, 6'd3, 2'b00, 8'd1, "R12");
        lookup(26'h0000007, 6'd3, 2'b00, 8'd1, "R4");     // RO load ok
        lookup(26'h0000007, 6'd9, 2'b01, 8'd1, "R6");     // RO store fault
        lookup(26'h0000007, 6'd9, 2'b10, 8'd1, "R6");     // RO fetch fault
        lookup(26'h0000007, 6'd9, 2'b00, 8'd2, "R2");     // other domain miss
        lookup(26'h0000007, 6'd9, 2'b11, 8'd1, "R6");     // reserved kind fault

        // R3: masked region of 1024 blocks, execute-read
        set_fill(8'd1, 26'h0009800, 26'h00003FF, 0, 2'b11, '0);
        cyc("R10");
        lookup(26'h0009800, 6'd0, 2'b10, 8'd1, "R3");
        lookup(26'h0009BFF, 6'd63, 2'b10, 8'd1, "R3");
        lookup(26'h0009A37, 6'd5, 2'b01, 8'd1, "R3");
        lookup(26'h0009C00, 6'd0, 2'b10, 8'd1, "R3");     // outside -> miss
        lookup(26'h0009A37, 6'd5, 2'b00, 8'd1, "R3");

        // R5: vector entry, word i gets code i%4
        vpat = '0;
        for (int i = 0; i < 64; i++) vpat[2*i +: 2] = 2'(i % 4);
        set_fill(8'd1, 26'h0000020, '0, 1, 2'b00, vpat);
        cyc("R5");
        for (int i = 0; i < 8; i++) begin
            lookup(26'h0000020, 6'(i), 2'(i % 3), 8'd1, "R5");
        end
        lookup(26'h0000020, 6'd63, 2'b10, 8'd1, "R5");
        lookup(26'h0000020, 6'd62, 2'b01, 8'd1, "R5");

        // R7: exact RW entry inside the XR region wins; tie keeps lower slot
        set_fill(8'd1, 26'h0009A37, '0, 0, 2'b10, '0);
        cyc("R7");
        lookup(26'h0009A37, 6'd1, 2'b01, 8'd1, "R7");
        lookup(26'h0009A38, 6'd1, 2'b01, 8'd1, "R7");
        set_fill(8'd1, 26'h0009A37, '0, 0, 2'b00, '0);
        cyc("R7");
        lookup(26'h0009A37, 6'd1, 2'b01, 8'd1, "R7");

        // R11: flush with a same-cycle fill
        flush = 1;
        set_fill(8'd1, 26'h0000200, '0, 0, 2'b10, '0);
        cyc("R11");
        lookup(26'h0000200, 6'd0, 2'b00, 8'd1, "R11");
        lookup(26'h0000007, 6'd0, 2'b00, 8'd1, "R11");

        // R10: nine fills, the ninth replaces the first
        for (int i = 0; i < 9; i++) begin
            set_fill(8'd3, 26'(32'h100 + i), '0, 0, 2'b01, '0);
            cyc("R10");
        end
        lookup(26'h0000100, 6'd0, 2'b00, 8'd3, "R10");
        lookup(26'h0000101, 6'd0, 2'b00, 8'd3, "R10");
        lookup(26'h0000108, 6'd0, 2'b00, 8'd3, "R10");
        cyc("R8");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule